// File: doc/BRIEF.md
# Card Data FIFO with Threshold Requests

This block is the data path between a host bus and the byte stream of a memory card. A 32-entry FIFO of 16-bit words sits in the middle. Each word carries two card bytes, low byte first. While a transfer runs, the block counts bytes within each block and blocks within the transfer. When the transfer completes, it pulses an end signal and sets a sticky done bit.

A transfer is started with a direction. In receive mode, card bytes flow into the FIFO and the bus drains it. In transmit mode, the bus fills the FIFO and the card drains it. Two programmable levels watch the FIFO occupancy. When the occupancy crosses the almost-full level (receive) or the almost-empty level (transmit), the block either raises a DMA request or sets a status flag. Which of the two happens depends on a per-direction DMA enable. Command decoding and response handling belong to a neighbouring block.

Top module: `card_data_fifo`

## Requirements
- R1: Words pushed by the bus outside a transfer are popped in the same order. The read and write indices wrap modulo 32, and the FIFO holds up to 32 words.
- R2: A bus push while 32 words are held is dropped. A bus pop from an empty FIFO returns the word at the read index and moves no pointer. `busRData` always shows the word at the read index.
- R3: When receiving, the first card byte of a word fills bits [7:0] and the second fills bits [15:8]. The last byte of a block with an odd byte count ends its word with bits [15:8] set to zero.
- R4: When transmitting, a word sends bits [7:0] first, then bits [15:8] only if bytes of the current block remain. The word leaves the FIFO after its last byte. An offered byte holds steady until it is accepted.
- R5: A block is `blkLenCfg`+1 bytes and a transfer is `blkCntCfg`+1 blocks. After the final byte, the card handshake stops, `xferEnd` pulses for one cycle and `statDone` sets. `statDone` stays set until `doneClr`.
- R6: When receiving, `cardRxReady` is high mid-word. At a word start it is high only while the occupancy is not above `afLevel`.
- R7: While the direction is receive and the occupancy is above `afLevel`, `rxDmaReq` is high if `rxDmaEn` is set; otherwise `statAlmostFull` is high. In every other case both are low.
- R8: While the direction is transmit and the occupancy is below `aeLevel`, `txDmaReq` is high if `txDmaEn` is set; otherwise `statAlmostEmpty` is high. In every other case both are low.
- R9: With no transfer active and the FIFO empty, `statAlmostFull`, `statAlmostEmpty`, `rxDmaReq` and `txDmaReq` are all low.
- R10: `startXfer` empties the FIFO and latches `startDir` (1 = receive from card, 0 = transmit to card).
- R11: During an active receive, bus pushes are ignored. During an active transmit, bus pops are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startXfer | input | 1 | Start pulse: flush FIFO, load counters |
| startDir | input | 1 | Direction for the start: 1 receive, 0 transmit |
| blkLenCfg | input | 11 | Bytes per block minus one |
| blkCntCfg | input | 11 | Blocks per transfer minus one |
| afLevel | input | 5 | Almost-full level (receive) |
| aeLevel | input | 5 | Almost-empty level (transmit) |
| rxDmaEn | input | 1 | Receive threshold raises DMA instead of flag |
| txDmaEn | input | 1 | Transmit threshold raises DMA instead of flag |
| doneClr | input | 1 | Clears the done bit |
| busPush | input | 1 | Bus write of one word |
| busWData | input | 16 | Bus write word |
| busPop | input | 1 | Bus read of one word |
| busRData | output | 16 | Word at the read index |
| cardRxValid | input | 1 | Card offers a received byte |
| cardRxByte | input | 8 | Received byte |
| cardRxReady | output | 1 | Block accepts a received byte |
| cardTxValid | output | 1 | Block offers a byte to the card |
| cardTxByte | output | 8 | Byte to the card |
| cardTxReady | input | 1 | Card accepts the offered byte |
| rxDmaReq | output | 1 | Receive DMA request |
| txDmaReq | output | 1 | Transmit DMA request |
| statDone | output | 1 | Transfer finished (sticky) |
| statAlmostFull | output | 1 | Receive threshold flag |
| statAlmostEmpty | output | 1 | Transmit threshold flag |
| xferEnd | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The hardest state to reach is a receive stall: the FIFO sits above the almost-full level at a word boundary, and the transfer still has bytes outstanding. The stimulus sets a low almost-full level and a block longer than the stall point. It feeds just enough bytes to cross the level, then toggles the DMA enable while the card is held off. It drains through the bus and feeds the rest, which also leaves a completed transfer with data still queued above the level. Odd-length blocks in both directions check the half-word ending, and long random push/pop runs outside transfers exercise pointer wrap and the full/empty edges.

// File: rtl/card_fifo_pkg.sv
package card_fifo_pkg;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;

  // Strobes from control to the storage datapath
  typedef struct packed {
    logic              flush;
    logic              push;
    logic              pop;
    logic [WORD_W-1:0] pushData;
  } fifoStrobe_t;
endpackage

// File: rtl/card_fifo_store.sv
module card_fifo_store
  import card_fifo_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrobe_t       st,
  output logic [AW:0]       count,
  output logic [WORD_W-1:0] headWord,
  output logic              full,
  output logic              empty
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wrIdx;
  logic [AW-1:0]     rdIdx;

  assign full     = (count == (AW+1)'(DEPTH));
  assign empty    = (count == '0);
  assign headWord = mem[rdIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrIdx <= '0;
      rdIdx <= '0;
      count <= '0;
    end else if (st.flush) begin
      wrIdx <= '0;
      rdIdx <= '0;
      count <= '0;
    end else begin
      if (st.push) wrIdx <= wrIdx + 1'b1;
      if (st.pop)  rdIdx <= rdIdx + 1'b1;
      case ({st.push, st.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // Storage array, cleared at reset so an empty read is defined
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (st.push && !st.flush) begin
      mem[wrIdx] <= st.pushData;
    end
  end

  // R1: occupancy never exceeds the depth
  a_r1_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    count <= (AW+1)'(DEPTH));

  // R2: control never pushes into a full store without a pop
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (full && !st.pop && !st.flush) |-> !st.push);

  // R2: control never pops an empty store
  a_r2_no_underflow: assert property (@(posedge clk) disable iff (!rstN)
    (empty && !st.flush) |-> !st.pop);
endmodule

// File: rtl/card_fifo_ctl.sv
module card_fifo_ctl
  import card_fifo_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int LEN_W = 11,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startXfer,
  input  logic              startDir,
  input  logic [LEN_W-1:0]  blkLenCfg,
  input  logic [LEN_W-1:0]  blkCntCfg,
  input  logic [AW-1:0]     afLevel,
  input  logic [AW-1:0]     aeLevel,
  input  logic              rxDmaEn,
  input  logic              txDmaEn,
  input  logic              doneClr,
  input  logic              busPush,
  input  logic [WORD_W-1:0] busWData,
  input  logic              busPop,
  input  logic              cardRxValid,
  input  logic [BYTE_W-1:0] cardRxByte,
  output logic              cardRxReady,
  output logic              cardTxValid,
  output logic [BYTE_W-1:0] cardTxByte,
  input  logic              cardTxReady,
  output logic              rxDmaReq,
  output logic              txDmaReq,
  output logic              statDone,
  output logic              statAlmostFull,
  output logic              statAlmostEmpty,
  output logic              xferEnd,
  input  logic [AW:0]       count,
  input  logic [WORD_W-1:0] headWord,
  input  logic              full,
  input  logic              empty,
  output fifoStrobe_t       st
);
  localparam int CW = LEN_W + 1;

  logic              active;
  logic              dirRx;
  logic [CW-1:0]     byteCnt;
  logic [CW-1:0]     blkCnt;
  logic [CW-1:0]     byteReload;
  logic [CW-1:0]     blkReload;
  logic              rxHasLow;
  logic [BYTE_W-1:0] rxLowByte;
  logic              txHigh;

  logic rxGo, txGo, rxAcc, txAcc, byteStep;
  logic lastOfBlock, lastBlock;
  logic cardPushW, txPopW, busPushOk, busPopOk;
  logic idleEmpty, rxCond, txCond;

  assign rxGo = active && dirRx;
  assign txGo = active && !dirRx;

  // Receive side: stall only at a word boundary
  assign cardRxReady = rxGo && (rxHasLow || (count <= {1'b0, afLevel}));
  assign rxAcc       = cardRxValid && cardRxReady;

  // Transmit side: low half first, then high half
  assign cardTxValid = txGo && !empty;
  assign cardTxByte  = txHigh ? headWord[WORD_W-1:BYTE_W] : headWord[BYTE_W-1:0];
  assign txAcc       = cardTxValid && cardTxReady;

  assign byteStep    = rxAcc || txAcc;
  assign lastOfBlock = (byteCnt == CW'(1));
  assign lastBlock   = (blkCnt == CW'(1));

  assign cardPushW = rxAcc && (rxHasLow || lastOfBlock);
  assign txPopW    = txAcc && (txHigh || lastOfBlock);
  assign busPushOk = busPush && !rxGo && !full;
  assign busPopOk  = busPop && !txGo && !empty;

  always_comb begin
    st.flush = startXfer;
    st.push  = cardPushW || busPushOk;
    st.pop   = txPopW || busPopOk;
    if (cardPushW)
      st.pushData = rxHasLow ? {cardRxByte, rxLowByte} : {{BYTE_W{1'b0}}, cardRxByte};
    else
      st.pushData = busWData;
  end

  // Byte and block counting
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active     <= 1'b0;
      dirRx      <= 1'b0;
      byteCnt    <= '0;
      blkCnt     <= '0;
      byteReload <= '0;
      blkReload  <= '0;
      rxHasLow   <= 1'b0;
      rxLowByte  <= '0;
      txHigh     <= 1'b0;
      xferEnd    <= 1'b0;
    end else begin
      xferEnd <= 1'b0;
      if (startXfer) begin
        active     <= 1'b1;
        dirRx      <= startDir;
        byteCnt    <= {1'b0, blkLenCfg} + 1'b1;
        blkCnt     <= {1'b0, blkCntCfg} + 1'b1;
        byteReload <= {1'b0, blkLenCfg} + 1'b1;
        blkReload  <= {1'b0, blkCntCfg} + 1'b1;
        rxHasLow   <= 1'b0;
        txHigh     <= 1'b0;
      end else if (byteStep) begin
        if (rxAcc && !rxHasLow) rxLowByte <= cardRxByte;
        if (lastOfBlock) begin
          byteCnt  <= byteReload;
          rxHasLow <= 1'b0;
          txHigh   <= 1'b0;
          if (lastBlock) begin
            blkCnt  <= blkReload;
            active  <= 1'b0;
            xferEnd <= 1'b1;
          end else begin
            blkCnt <= blkCnt - 1'b1;
          end
        end else begin
          byteCnt <= byteCnt - 1'b1;
          if (rxAcc) rxHasLow <= !rxHasLow;
          if (txAcc) txHigh   <= !txHigh;
        end
      end
    end
  end

  // Sticky done bit, set wins over clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                             statDone <= 1'b0;
    else if (byteStep && lastOfBlock && lastBlock && !startXfer) statDone <= 1'b1;
    else if (doneClr)                      statDone <= 1'b0;
  end

  // Threshold evaluation, registered
  assign idleEmpty = !active && empty;
  assign rxCond    = dirRx && (count > {1'b0, afLevel});
  assign txCond    = !dirRx && (count < {1'b0, aeLevel});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxDmaReq        <= 1'b0;
      txDmaReq        <= 1'b0;
      statAlmostFull  <= 1'b0;
      statAlmostEmpty <= 1'b0;
    end else if (idleEmpty) begin
      rxDmaReq        <= 1'b0;
      txDmaReq        <= 1'b0;
      statAlmostFull  <= 1'b0;
      statAlmostEmpty <= 1'b0;
    end else begin
      rxDmaReq        <= rxCond && rxDmaEn;
      statAlmostFull  <= rxCond && !rxDmaEn;
      txDmaReq        <= txCond && txDmaEn;
      statAlmostEmpty <= txCond && !txDmaEn;
    end
  end

  // R5: the end pulse coincides with the done bit
  a_r5_end_sets_done: assert property (@(posedge clk) disable iff (!rstN)
    xferEnd |-> statDone);

  // R7: receive request and receive flag never both high
  a_r7_rx_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(rxDmaReq && statAlmostFull));

  // R8: transmit request and transmit flag never both high
  a_r8_tx_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(txDmaReq && statAlmostEmpty));

  // R9: idle and empty leaves no request or flag one cycle later
  a_r9_idle_clear: assert property (@(posedge clk) disable iff (!rstN)
    (!active && empty) |=> !(rxDmaReq || txDmaReq || statAlmostFull || statAlmostEmpty));

  // R4: an offered byte holds until the card takes it
  a_r4_tx_hold: assert property (@(posedge clk) disable iff (!rstN)
    (cardTxValid && !cardTxReady && !startXfer) |=> (cardTxValid && $stable(cardTxByte)));
endmodule

// File: rtl/card_data_fifo.sv
module card_data_fifo
  import card_fifo_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int LEN_W = 11,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startXfer,
  input  logic              startDir,
  input  logic [LEN_W-1:0]  blkLenCfg,
  input  logic [LEN_W-1:0]  blkCntCfg,
  input  logic [AW-1:0]     afLevel,
  input  logic [AW-1:0]     aeLevel,
  input  logic              rxDmaEn,
  input  logic              txDmaEn,
  input  logic              doneClr,
  input  logic              busPush,
  input  logic [WORD_W-1:0] busWData,
  input  logic              busPop,
  output logic [WORD_W-1:0] busRData,
  input  logic              cardRxValid,
  input  logic [BYTE_W-1:0] cardRxByte,
  output logic              cardRxReady,
  output logic              cardTxValid,
  output logic [BYTE_W-1:0] cardTxByte,
  input  logic              cardTxReady,
  output logic              rxDmaReq,
  output logic              txDmaReq,
  output logic              statDone,
  output logic              statAlmostFull,
  output logic              statAlmostEmpty,
  output logic              xferEnd
);
  fifoStrobe_t       st;
  logic [AW:0]       count;
  logic [WORD_W-1:0] headWord;
  logic              full;
  logic              empty;

  assign busRData = headWord;

  card_fifo_ctl #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_ctl (
    .clk(clk), .rstN(rstN),
    .startXfer(startXfer), .startDir(startDir),
    .blkLenCfg(blkLenCfg), .blkCntCfg(blkCntCfg),
    .afLevel(afLevel), .aeLevel(aeLevel),
    .rxDmaEn(rxDmaEn), .txDmaEn(txDmaEn), .doneClr(doneClr),
    .busPush(busPush), .busWData(busWData), .busPop(busPop),
    .cardRxValid(cardRxValid), .cardRxByte(cardRxByte), .cardRxReady(cardRxReady),
    .cardTxValid(cardTxValid), .cardTxByte(cardTxByte), .cardTxReady(cardTxReady),
    .rxDmaReq(rxDmaReq), .txDmaReq(txDmaReq), .statDone(statDone),
    .statAlmostFull(statAlmostFull), .statAlmostEmpty(statAlmostEmpty),
    .xferEnd(xferEnd),
    .count(count), .headWord(headWord), .full(full), .empty(empty),
    .st(st)
  );

  card_fifo_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rstN(rstN), .st(st),
    .count(count), .headWord(headWord), .full(full), .empty(empty)
  );
endmodule

// File: tb/tb_card_data_fifo.sv
`timescale 1ns/1ps
module tb_card_data_fifo;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startXfer = 0, startDir = 0;
  logic [10:0] blkLenCfg = '0, blkCntCfg = '0;
  logic [4:0] afLevel = 5'd31, aeLevel = 5'd0;
  logic rxDmaEn = 0, txDmaEn = 0, doneClr = 0;
  logic busPush = 0, busPop = 0;
  logic [15:0] busWData = '0;
  logic [15:0] busRData;
  logic cardRxValid = 0;
  logic [7:0] cardRxByte = '0;
  logic cardRxReady, cardTxValid;
  logic [7:0] cardTxByte;
  logic cardTxReady = 0;
  logic rxDmaReq, txDmaReq, statDone, statAlmostFull, statAlmostEmpty, xferEnd;

  int checks = 0, fails = 0, endCount = 0;
  bit finished = 0;

  // model of bus-side storage
  logic [15:0] mMem [32];
  int mRd = 0, mWr = 0, mCnt = 0;

  always #2 clk = ~clk;

  card_data_fifo dut (.*);

  always @(posedge clk) if (rstN && xferEnd) endCount++;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pushWord(input logic [15:0] d);
    busWData = d; busPush = 1;
    @(negedge clk);
    busPush = 0;
  endtask

  task automatic pushModel(input logic [15:0] d);
    pushWord(d);
    if (mCnt < 32) begin mMem[mWr] = d; mWr = (mWr + 1) % 32; mCnt++; end
  endtask

  task automatic popModel(input string tag);
    logic [15:0] exp;
    exp = mMem[mRd];
    chk(busRData == exp, tag, busRData, exp);
    busPop = 1;
    @(negedge clk);
    busPop = 0;
    if (mCnt > 0) begin mRd = (mRd + 1) % 32; mCnt--; end
  endtask

  task automatic popCheck(input logic [15:0] exp, input string tag);
    chk(busRData == exp, tag, busRData, exp);
    busPop = 1;
    @(negedge clk);
    busPop = 0;
  endtask

  task automatic feedByte(input logic [7:0] b);
    int t;
    cardRxValid = 1; cardRxByte = b; t = 0;
    while (!cardRxReady && t < 200) begin @(negedge clk); t++; end
    @(negedge clk);
    cardRxValid = 0;
    if (t >= 200) chk(0, "R6 feed timeout", 0, 1);
  endtask

  task automatic sinkByte(input logic [7:0] exp, input string tag);
    int t;
    t = 0;
    while (!cardTxValid && t < 200) begin @(negedge clk); t++; end
    chk(cardTxValid && cardTxByte == exp, tag, cardTxByte, exp);
    cardTxReady = 1;
    @(negedge clk);
    cardTxReady = 0;
  endtask

  task automatic startIt(input bit dir);
    startDir = dir; startXfer = 1;
    @(negedge clk);
    startXfer = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed;
    for (int i = 0; i < 32; i++) mMem[i] = '0;
    seed = $urandom(32'h5EED);
    waitCyc(3);
    rstN = 1;
    waitCyc(2);
    // reset state
    chk({rxDmaReq, txDmaReq, statDone, statAlmostFull, statAlmostEmpty, xferEnd} == 6'b0,
        "reset outputs", {rxDmaReq, txDmaReq, statDone, statAlmostFull, statAlmostEmpty}, 0);
    chk(!cardRxReady && !cardTxValid, "reset card side", {cardRxReady, cardTxValid}, 0);

    // R1 R2: random bus traffic outside a transfer
    for (int i = 0; i < 400; i++) begin
      int op;
      op = $urandom % 5;
      if (op < 2)      pushModel(16'($urandom));
      else if (op < 4) popModel("R1 random pop order");
      else             waitCyc(1);
    end
    // R2: overfill then overdrain
    for (int i = 0; i < 36; i++) pushModel(16'($urandom));
    for (int i = 0; i < 34; i++) popModel("R2 full-drop and empty-pop");
    waitCyc(2);
    chk(!statAlmostFull && !statAlmostEmpty, "R9 idle empty flags", {statAlmostFull, statAlmostEmpty}, 0);

    // R10: start flushes queued words
    afLevel = 5'd0;
    pushWord(16'h1111); pushWord(16'h2222); pushWord(16'h3333);
    startIt(1);
    waitCyc(3);
    chk(statAlmostFull == 0, "R10 flush on start", statAlmostFull, 0);
    chk(cardRxReady == 1, "R10 receive direction latched", cardRxReady, 1);

    // R3 R5 R11: receive 2 blocks of 3 bytes
    afLevel = 5'd31; blkLenCfg = 11'd2; blkCntCfg = 11'd1;
    startIt(1);
    pushWord(16'hBEEF);   // ignored while receiving
    feedByte(8'h11); feedByte(8'h22); feedByte(8'h33);
    feedByte(8'h44); feedByte(8'h55); feedByte(8'h66);
    waitCyc(3);
    chk(statDone == 1, "R5 done after rx", statDone, 1);
    chk(endCount == 1, "R5 one end pulse", endCount, 1);
    chk(cardRxReady == 0, "R5 rx stops at end", cardRxReady, 0);
    popCheck(16'h2211, "R3 R11 first word packed, bus push ignored");
    popCheck(16'h0033, "R3 odd tail");
    popCheck(16'h5544, "R3 second block");
    popCheck(16'h0066, "R3 odd tail block 2");
    doneClr = 1; @(negedge clk); doneClr = 0;
    waitCyc(1);
    chk(statDone == 0, "R5 done cleared", statDone, 0);

    // R6 R7: receive stall above almost-full
    afLevel = 5'd1; blkLenCfg = 11'd7; blkCntCfg = 11'd0;
    startIt(1);
    feedByte(8'hA0); feedByte(8'hA1); feedByte(8'hA2); feedByte(8'hA3);
    waitCyc(3);
    chk(cardRxReady == 0, "R6 stall above level", cardRxReady, 0);
    chk(statAlmostFull == 1 && rxDmaReq == 0, "R7 flag without dma", {statAlmostFull, rxDmaReq}, 2'b10);
    rxDmaEn = 1;
    waitCyc(2);
    chk(rxDmaReq == 1 && statAlmostFull == 0, "R7 dma request", {statAlmostFull, rxDmaReq}, 2'b01);
    popCheck(16'hA1A0, "R3 stall word 0");
    popCheck(16'hA3A2, "R3 stall word 1");
    waitCyc(2);
    chk(cardRxReady == 1 && rxDmaReq == 0, "R6 resume below level", {cardRxReady, rxDmaReq}, 2'b10);
    feedByte(8'hA4); feedByte(8'hA5); feedByte(8'hA6); feedByte(8'hA7);
    waitCyc(3);
    chk(statDone == 1 && endCount == 2, "R5 done stall rx", endCount, 2);
    chk(rxDmaReq == 1, "R7 request held after end with data", rxDmaReq, 1);
    popCheck(16'hA5A4, "R3 word 2");
    popCheck(16'hA7A6, "R3 word 3");
    waitCyc(2);
    chk(rxDmaReq == 0 && statAlmostFull == 0, "R9 idle clears rx", {rxDmaReq, statAlmostFull}, 0);
    rxDmaEn = 0;
    doneClr = 1; @(negedge clk); doneClr = 0;

    // R4 R8 R11: transmit one block of 5 bytes
    aeLevel = 5'd2; blkLenCfg = 11'd4; blkCntCfg = 11'd0;
    startIt(0);
    waitCyc(2);
    chk(statAlmostEmpty == 1 && txDmaReq == 0, "R8 flag when low", {statAlmostEmpty, txDmaReq}, 2'b10);
    pushWord(16'hB1A1); pushWord(16'hB2A2); pushWord(16'hB3A3);
    waitCyc(2);
    chk(statAlmostEmpty == 0, "R8 flag clears above level", statAlmostEmpty, 0);
    busPop = 1; @(negedge clk); busPop = 0;
    waitCyc(1);
    chk(busRData == 16'hB1A1, "R11 bus pop ignored in tx", busRData, 16'hB1A1);
    sinkByte(8'hA1, "R4 byte 0");
    sinkByte(8'hB1, "R4 byte 1");
    sinkByte(8'hA2, "R4 byte 2");
    sinkByte(8'hB2, "R4 byte 3");
    sinkByte(8'hA3, "R4 byte 4 low only");
    waitCyc(3);
    chk(statDone == 1 && endCount == 3, "R5 done tx", endCount, 3);
    chk(cardTxValid == 0, "R4 high half unused and word gone", cardTxValid, 0);
    chk(!statAlmostEmpty && !txDmaReq, "R9 idle clears tx", {statAlmostEmpty, txDmaReq}, 0);

    // R8: transmit with DMA, single byte
    txDmaEn = 1; blkLenCfg = 11'd0;
    startIt(0);
    waitCyc(2);
    chk(txDmaReq == 1 && statAlmostEmpty == 0, "R8 dma request", {statAlmostEmpty, txDmaReq}, 2'b01);
    pushWord(16'h55C7);
    waitCyc(2);
    chk(txDmaReq == 1, "R8 still below level", txDmaReq, 1);
    sinkByte(8'hC7, "R4 single byte");
    waitCyc(3);
    chk(txDmaReq == 0 && endCount == 4, "R9 tx dma idle", {txDmaReq, 8'(endCount)}, 4);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule